// File: doc/BRIEF.md
# Dual-Band Power AGC Decision

This block sits behind a receive data path and turns measured signal power into gain-step requests for a slow automatic gain loop. It squares and sums each accepted I/Q sample, averages the result over a window whose length is set by a 4-bit duration code, and converts each finished window's mean into a level in whole dB below full scale. Full scale is taken as a complex tone of peak amplitude 2^(DATA_W-1), which is a mean power of 2^(2*DATA_W-2).

Each finished window updates four sticky flags that describe an upper band and a lower band. An upper reference in dB below full scale, less a 4-bit offset, gives the outer upper edge. A lower reference, plus a 4-bit offset, gives the outer lower edge. When the update-period pulse arrives, the flags collected during that period pick at most one request. A decrease wins over an increase, and the outer edge of a band wins over its inner edge. Each of the four edges carries its own 5-bit step size. The 2-bit measurement select switches the block off when it is 00; its value is echoed as a status so the surrounding logic can see which tap feeds the meter.

The sample input is a valid/ready stream. Ready is low only in the cycle that carries the update pulse, so upstream holds a sample offered in that cycle and presents it again in the next one. There is no other back-pressure. The request output is a single-cycle strobe that cannot be stalled.

Top module: `agc_pwr_decision`

## Requirements
- R1: While reset is asserted, req_valid, req_up, req_mag and tap_stat are all zero.
- R2: s_ready is 0 in a cycle where upd_pulse is 1 and 1 otherwise. A sample is taken only when s_valid and s_ready are both 1.
- R3: A window holds exactly 8 << meas_dur accepted samples. Its mean is the sum of I*I + Q*Q over those samples, divided by the window length.
- R4: A window's level is 10*log10(2^(2*DATA_W-2) / mean), rounded to whole dB and clamped at 0. A window with a mean of zero reads as level 255.
- R5: If any window in the period had a level strictly below ul_thr - uh_ofs, the request is a decrease (req_up=0) of step_uh.
- R6: Otherwise, if any window in the period had a level strictly below ul_thr, the request is a decrease of step_ul.
- R7: Otherwise, if no window in the period had a level at or below lh_thr + ll_ofs, the request is an increase (req_up=1) of step_ll.
- R8: Otherwise, if no window in the period had a level at or below lh_thr, the request is an increase of step_lh.
- R9: If the period had at least one window and none of R5 to R8 applies, no request is issued.
- R10: A request appears as req_valid=1 for exactly the one cycle after the cycle with upd_pulse=1, and only if at least one window finished in that period. In every other cycle req_valid, req_up and req_mag are all 0.
- R11: An upd_pulse discards a partly filled window, and that window adds nothing to the next period.
- R12: With meas_cfg=00 no request is ever issued. tap_stat shows meas_cfg delayed by one clock (00 off, 01 half-band output, 10 FIR output, 11 DC-corrected output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (low in the boundary cycle) |
| s_i | input | DATA_W | In-phase sample, signed |
| s_q | input | DATA_W | Quadrature sample, signed |
| meas_cfg | input | 2 | Measurement tap select; 00 disables |
| meas_dur | input | DUR_W | Window code; window = 8 << code samples |
| upd_pulse | input | 1 | Gain update period boundary |
| ul_thr | input | THR_W | Upper inner edge, dB below full scale |
| uh_ofs | input | OFS_W | Upper outer edge, dB above ul_thr |
| lh_thr | input | THR_W | Lower inner edge, dB below full scale |
| ll_ofs | input | OFS_W | Lower outer edge, dB beyond lh_thr |
| step_uh | input | STEP_W | Decrease size at the upper outer edge |
| step_ul | input | STEP_W | Decrease size at the upper inner edge |
| step_lh | input | STEP_W | Increase size at the lower inner edge |
| step_ll | input | STEP_W | Increase size at the lower outer edge |
| req_valid | output | 1 | Gain-step request strobe |
| req_up | output | 1 | 1 = increase gain, 0 = decrease |
| req_mag | output | STEP_W | Step size in gain indices |
| tap_stat | output | 2 | Registered copy of meas_cfg |

## Verification
Constant tones are placed at about 0, 2, 7, 14 and 20 dB below full scale, plus an all-zero input, so that each level falls in a different band region and each band edge is exercised once. Equal I and Q tones show that the quadrature path is summed. A half-silent, half-loud window checks that the mean is taken over the whole window and not over eight samples. A loud window followed by a quiet window in the same period separates sticky flags from last-window-only behaviour. Moved references and offsets, short windows cut by the boundary, and a disabled interval confirm that each edge decides on its own and that partial windows are dropped.

// File: rtl/agc_pwr_pkg.sv
package agc_pwr_pkg;

  // Levels are carried in whole dB below full scale
  localparam int LVL_W = 8;
  localparam logic [LVL_W-1:0] LVL_SILENT = 8'hFF;
  localparam logic [LVL_W-1:0] LVL_CLAMP  = 8'hFE;

  // Log approximation: 4 mantissa bits, 1/16-octave units
  localparam int FRAC_B  = 4;
  // 10*log10(2)/16 scaled by 1024
  localparam int LOG_MUL = 193;

  typedef enum logic [2:0] {
    DEC_HOLD,
    DEC_DN_OUTER,
    DEC_DN_INNER,
    DEC_UP_OUTER,
    DEC_UP_INNER
  } dec_e;

  // 16*log2(1 + f/16), rounded
  function automatic logic [4:0] frac_q4(input logic [FRAC_B-1:0] f);
    case (f)
      4'd0:    frac_q4 = 5'd0;
      4'd1:    frac_q4 = 5'd1;
      4'd2:    frac_q4 = 5'd3;
      4'd3:    frac_q4 = 5'd4;
      4'd4:    frac_q4 = 5'd5;
      4'd5:    frac_q4 = 5'd6;
      4'd6:    frac_q4 = 5'd7;
      4'd7:    frac_q4 = 5'd8;
      4'd8:    frac_q4 = 5'd9;
      4'd9:    frac_q4 = 5'd10;
      4'd10:   frac_q4 = 5'd11;
      4'd11:   frac_q4 = 5'd12;
      4'd12:   frac_q4 = 5'd13;
      4'd13:   frac_q4 = 5'd14;
      default: frac_q4 = 5'd15;
    endcase
  endfunction

endpackage

// File: rtl/agc_pwr_accum.sv
module agc_pwr_accum #(
  parameter int DATA_W    = 16,
  parameter int DUR_W     = 4,
  parameter int BASE_LOG2 = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic                     smp_ok,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [DATA_W-1:0] smp_q,
  input  logic [DUR_W-1:0]         dur,
  output logic                     mean_valid,
  output logic [2*DATA_W-1:0]      mean
);
  localparam int PWR_W  = 2 * DATA_W;
  localparam int MAX_SH = BASE_LOG2 + (1 << DUR_W) - 1;
  localparam int ACC_W  = PWR_W + MAX_SH;
  localparam int CNT_W  = MAX_SH + 1;

  logic signed [PWR_W-1:0] sq_i, sq_q;
  logic [PWR_W-1:0]        pwr;
  logic [ACC_W-1:0]        acc, acc_nxt;
  logic [CNT_W-1:0]        cnt, win_len;
  int                      shamt;
  logic                    win_last;

  always_comb begin
    sq_i     = smp_i * smp_i;
    sq_q     = smp_q * smp_q;
    pwr      = $unsigned(sq_i) + $unsigned(sq_q);
    acc_nxt  = acc + ACC_W'(pwr);
    shamt    = BASE_LOG2 + int'(dur);
    win_len  = CNT_W'(1) << shamt;
    win_last = (cnt == win_len - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      cnt        <= '0;
      mean       <= '0;
      mean_valid <= 1'b0;
    end else if (clr || !en) begin
      acc        <= '0;
      cnt        <= '0;
      mean_valid <= 1'b0;
    end else begin
      mean_valid <= 1'b0;
      if (smp_ok) begin
        if (win_last) begin
          mean       <= PWR_W'(acc_nxt >> shamt);
          mean_valid <= 1'b1;
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_MEAN_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid |-> $past(smp_ok)); // R3
  AST_MEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid |-> (mean <= (PWR_W'(1) << (PWR_W-1)))); // R3

endmodule

// File: rtl/agc_pwr_log.sv
module agc_pwr_log
  import agc_pwr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mean_valid,
  input  logic [2*DATA_W-1:0]   mean,
  output logic                  lvl_valid,
  output logic [LVL_W-1:0]      lvl
);
  localparam int PWR_W = 2 * DATA_W;
  localparam int FS_Q4 = (2 * DATA_W - 2) << FRAC_B;

  logic [LVL_W-1:0] lvl_nxt;

  always_comb begin
    int k;
    int l2;
    int att;
    int db;
    logic [FRAC_B-1:0] fr;
    k = 0;
    for (int b = 0; b < PWR_W; b++) begin
      if (mean[b]) k = b;
    end
    if (k >= FRAC_B) fr = FRAC_B'(mean >> (k - FRAC_B));
    else             fr = FRAC_B'(mean << (FRAC_B - k));
    l2  = (k << FRAC_B) + int'(frac_q4(fr));
    att = FS_Q4 - l2;
    if (att < 0) att = 0;
    db  = (att * LOG_MUL + 512) >>> 10;
    if (mean == '0)                lvl_nxt = LVL_SILENT;
    else if (db > int'(LVL_CLAMP)) lvl_nxt = LVL_CLAMP;
    else                           lvl_nxt = LVL_W'(db);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_valid <= 1'b0;
      lvl       <= '0;
    end else begin
      lvl_valid <= mean_valid;
      if (mean_valid) lvl <= lvl_nxt;
    end
  end

  AST_SILENT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid && ($past(mean) == '0)) |-> (lvl == LVL_SILENT)); // R4
  AST_LOUD_NOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid && ($past(mean) != '0)) |-> (lvl != LVL_SILENT)); // R4

endmodule

// File: rtl/agc_pwr_band.sv
module agc_pwr_band
  import agc_pwr_pkg::*;
#(
  parameter int THR_W  = 7,
  parameter int OFS_W  = 4,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              upd,
  input  logic              lvl_valid,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [THR_W-1:0]  ul_thr,
  input  logic [OFS_W-1:0]  uh_ofs,
  input  logic [THR_W-1:0]  lh_thr,
  input  logic [OFS_W-1:0]  ll_ofs,
  input  logic [STEP_W-1:0] step_uh,
  input  logic [STEP_W-1:0] step_ul,
  input  logic [STEP_W-1:0] step_lh,
  input  logic [STEP_W-1:0] step_ll,
  output logic              req_valid,
  output logic              req_up,
  output logic [STEP_W-1:0] req_mag
);
  logic f_any, f_uh, f_ul, f_lh, f_ll;
  logic hit_uh, hit_ul, hit_lh, hit_ll;
  dec_e dec;

  always_comb begin
    int lv;
    int uh_lim;
    int ll_lim;
    lv     = int'(lvl);
    uh_lim = int'(ul_thr) - int'(uh_ofs);
    ll_lim = int'(lh_thr) + int'(ll_ofs);
    hit_uh = lv < uh_lim;
    hit_ul = lv < int'(ul_thr);
    hit_lh = lv <= int'(lh_thr);
    hit_ll = lv <= ll_lim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || upd || !en) begin
      f_any <= 1'b0;
      f_uh  <= 1'b0;
      f_ul  <= 1'b0;
      f_lh  <= 1'b0;
      f_ll  <= 1'b0;
    end else if (lvl_valid) begin
      f_any <= 1'b1;
      f_uh  <= f_uh | hit_uh;
      f_ul  <= f_ul | hit_ul;
      f_lh  <= f_lh | hit_lh;
      f_ll  <= f_ll | hit_ll;
    end
  end

  always_comb begin
    dec = DEC_HOLD;
    if (en && f_any) begin
      if (f_uh)       dec = DEC_DN_OUTER;
      else if (f_ul)  dec = DEC_DN_INNER;
      else if (!f_ll) dec = DEC_UP_OUTER;
      else if (!f_lh) dec = DEC_UP_INNER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_up    <= 1'b0;
      req_mag   <= '0;
    end else if (upd && dec != DEC_HOLD) begin
      req_valid <= 1'b1;
      req_up    <= (dec == DEC_UP_OUTER) || (dec == DEC_UP_INNER);
      unique case (dec)
        DEC_DN_OUTER: req_mag <= step_uh;
        DEC_DN_INNER: req_mag <= step_ul;
        DEC_UP_OUTER: req_mag <= step_ll;
        default:      req_mag <= step_lh;
      endcase
    end else begin
      req_valid <= 1'b0;
      req_up    <= 1'b0;
      req_mag   <= '0;
    end
  end

  AST_REQ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(upd)); // R10
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R10
  AST_NO_RISE_UNDER_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_up) |-> !$past(f_ul || f_uh)); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(en)); // R12

endmodule

// File: rtl/agc_pwr_decision.sv
module agc_pwr_decision
  import agc_pwr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DUR_W     = 4,
  parameter int THR_W     = 7,
  parameter int OFS_W     = 4,
  parameter int STEP_W    = 5,
  parameter int BASE_LOG2 = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_i,
  input  logic signed [DATA_W-1:0] s_q,
  input  logic [1:0]               meas_cfg,
  input  logic [DUR_W-1:0]         meas_dur,
  input  logic                     upd_pulse,
  input  logic [THR_W-1:0]         ul_thr,
  input  logic [OFS_W-1:0]         uh_ofs,
  input  logic [THR_W-1:0]         lh_thr,
  input  logic [OFS_W-1:0]         ll_ofs,
  input  logic [STEP_W-1:0]        step_uh,
  input  logic [STEP_W-1:0]        step_ul,
  input  logic [STEP_W-1:0]        step_lh,
  input  logic [STEP_W-1:0]        step_ll,
  output logic                     req_valid,
  output logic                     req_up,
  output logic [STEP_W-1:0]        req_mag,
  output logic [1:0]               tap_stat
);
  localparam int PWR_W = 2 * DATA_W;

  logic              meas_en, smp_ok;
  logic              mean_valid, lvl_valid;
  logic [PWR_W-1:0]  mean;
  logic [LVL_W-1:0]  lvl;

  assign meas_en = (meas_cfg != 2'b00);
  assign s_ready = !upd_pulse;
  assign smp_ok  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) tap_stat <= 2'b00;
    else        tap_stat <= meas_cfg;
  end

  agc_pwr_accum #(.DATA_W(DATA_W), .DUR_W(DUR_W), .BASE_LOG2(BASE_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(meas_en), .clr(upd_pulse), .smp_ok(smp_ok),
    .smp_i(s_i), .smp_q(s_q), .dur(meas_dur),
    .mean_valid(mean_valid), .mean(mean)
  );

  agc_pwr_log #(.DATA_W(DATA_W)) u_log (
    .clk(clk), .rst_n(rst_n), .mean_valid(mean_valid), .mean(mean),
    .lvl_valid(lvl_valid), .lvl(lvl)
  );

  agc_pwr_band #(.THR_W(THR_W), .OFS_W(OFS_W), .STEP_W(STEP_W)) u_band (
    .clk(clk), .rst_n(rst_n), .en(meas_en), .upd(upd_pulse),
    .lvl_valid(lvl_valid), .lvl(lvl),
    .ul_thr(ul_thr), .uh_ofs(uh_ofs), .lh_thr(lh_thr), .ll_ofs(ll_ofs),
    .step_uh(step_uh), .step_ul(step_ul), .step_lh(step_lh), .step_ll(step_ll),
    .req_valid(req_valid), .req_up(req_up), .req_mag(req_mag)
  );

  AST_READY_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !$past(s_ready)) |-> $past(upd_pulse)); // R2
  AST_TAP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tap_stat == $past(meas_cfg))); // R12

endmodule

// File: tb/sim_agc_pwr_decision.sv
module sim_agc_pwr_decision;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic [1:0]        meas_cfg = 2'b10;
  logic [3:0]        meas_dur = 4'd0;
  logic              upd_pulse = 1'b0;
  logic [6:0]        ul_thr = 7'd3, lh_thr = 7'd12;
  logic [3:0]        uh_ofs = 4'd1, ll_ofs = 4'd4;
  logic [4:0]        step_uh = 5'd4, step_ul = 5'd2, step_lh = 5'd2, step_ll = 5'd4;
  logic              req_valid, req_up;
  logic [4:0]        req_mag;
  logic [1:0]        tap_stat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  agc_pwr_decision u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .meas_cfg(meas_cfg), .meas_dur(meas_dur),
    .upd_pulse(upd_pulse), .ul_thr(ul_thr), .uh_ofs(uh_ofs),
    .lh_thr(lh_thr), .ll_ofs(ll_ofs), .step_uh(step_uh), .step_ul(step_ul),
    .step_lh(step_lh), .step_ll(step_ll), .req_valid(req_valid),
    .req_up(req_up), .req_mag(req_mag), .tap_stat(tap_stat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic feed(input int a, input int b, input int n);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_i = 16'(a);
      s_q = 16'(b);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Issue one boundary and check the request against expectation (R2, R10)
  task automatic boundary(input string tag, input int ev, input int eu, input int em);
    repeat (5) @(negedge clk);
    upd_pulse = 1'b1;
    #1;
    chk({tag, " R2 ready low at boundary"}, int'(s_ready), 0);
    @(negedge clk);
    upd_pulse = 1'b0;
    #1;
    chk({tag, " R2 ready high after boundary"}, int'(s_ready), 1);
    chk({tag, " valid"}, int'(req_valid), ev);
    chk({tag, " up"}, int'(req_up), eu);
    chk({tag, " mag"}, int'(req_mag), em);
    @(negedge clk);
    chk({tag, " R10 strobe lasts one cycle"}, int'(req_valid), 0);
  endtask

  // Model of R4..R9 for a period with one window of mean power p
  task automatic expect_model(input string tag, input real p);
    int di, ev, eu, em;
    if (p <= 0.0) di = 255;
    else begin
      di = $rtoi(10.0 * $log10(1073741824.0 / p) + 0.5);
      if (di < 0) di = 0;
    end
    ev = 1; eu = 0; em = 0;
    if (di < int'(ul_thr) - int'(uh_ofs))      em = int'(step_uh);
    else if (di < int'(ul_thr))                em = int'(step_ul);
    else if (di > int'(lh_thr) + int'(ll_ofs)) begin eu = 1; em = int'(step_ll); end
    else if (di > int'(lh_thr))                begin eu = 1; em = int'(step_lh); end
    else ev = 0;
    boundary(tag, ev, eu, em);
  endtask

  task automatic set_defaults();
    ul_thr = 7'd3; uh_ofs = 4'd1; lh_thr = 7'd12; ll_ofs = 4'd4;
    step_uh = 5'd4; step_ul = 5'd2; step_lh = 5'd2; step_ll = 5'd4;
    meas_dur = 4'd0; meas_cfg = 2'b10;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 req_valid in reset", int'(req_valid), 0);
    chk("R1 req_up in reset", int'(req_up), 0);
    chk("R1 req_mag in reset", int'(req_mag), 0);
    chk("R1 tap_stat in reset", int'(tap_stat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 tap_stat echoes select", int'(tap_stat), 2);
    boundary("R10 empty period", 0, 0, 0);
  endtask

  task automatic t_levels();
    feed(32767, 0, 8); expect_model("R5 tone 0 dB", 32767.0 * 32767.0);
    feed(26029, 0, 8); expect_model("R6 tone 2 dB", 26029.0 * 26029.0);
    feed(14628, 0, 8); expect_model("R9 tone 7 dB", 14628.0 * 14628.0);
    feed(6540, 0, 8);  expect_model("R8 tone 14 dB", 6540.0 * 6540.0);
    feed(3277, 0, 8);  expect_model("R7 tone 20 dB", 3277.0 * 3277.0);
    feed(0, 0, 8);     expect_model("R4 R7 silent window", 0.0);
  endtask

  task automatic t_quadrature();
    feed(4624, 4624, 8);
    expect_model("R3 I and Q summed", 2.0 * 4624.0 * 4624.0);
  endtask

  task automatic t_window_avg();
    meas_dur = 4'd1; ul_thr = 7'd4; uh_ofs = 4'd3;
    step_uh = 5'd9; step_ul = 5'd7; step_lh = 5'd11; step_ll = 5'd13;
    feed(0, 0, 8);
    feed(32767, 0, 8);
    expect_model("R3 16-sample mean", 32767.0 * 32767.0 / 2.0);
    set_defaults();
  endtask

  task automatic t_partial();
    meas_dur = 4'd2;
    feed(32767, 0, 24);
    boundary("R11 partial window dropped", 0, 0, 0);
    feed(32767, 0, 16);
    boundary("R11 R3 16 of 32 samples", 0, 0, 0);
    feed(32767, 0, 32);
    boundary("R3 full 32-sample window", 1, 0, 4);
    set_defaults();
  endtask

  task automatic t_multi();
    feed(32767, 0, 8);
    feed(3277, 0, 8);
    boundary("R5 loud then quiet window", 1, 0, 4);
  endtask

  task automatic t_offsets();
    ul_thr = 7'd10; uh_ofs = 4'd5;
    feed(14628, 0, 8); expect_model("R6 moved upper edge", 14628.0 * 14628.0);
    feed(26029, 0, 8); expect_model("R5 moved upper offset", 26029.0 * 26029.0);
    set_defaults();
    lh_thr = 7'd20; ll_ofs = 4'd2;
    feed(6540, 0, 8); expect_model("R9 moved lower edge", 6540.0 * 6540.0);
    feed(3277, 0, 8); expect_model("R8 level equal to lower edge", 3277.0 * 3277.0);
    feed(0, 0, 8);    expect_model("R7 moved lower offset", 0.0);
    set_defaults();
  endtask

  task automatic t_disabled();
    meas_cfg = 2'b00;
    @(negedge clk);
    chk("R12 tap_stat off", int'(tap_stat), 0);
    feed(32767, 0, 8);
    boundary("R12 no request when off", 0, 0, 0);
    meas_cfg = 2'b11;
    @(negedge clk);
    chk("R12 tap_stat DC tap", int'(tap_stat), 3);
    feed(32767, 0, 8);
    boundary("R12 request after re-enable", 1, 0, 4);
    set_defaults();
  endtask

  initial begin
    t_reset();
    t_levels();
    t_quadrature();
    t_window_avg();
    t_partial();
    t_multi();
    t_offsets();
    t_disabled();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule